// File: doc/BRIEF.md
# Four-Lane Pipelined Dot-Product Accumulator

This block forms the dot product of two signed integer vectors of a fixed, parameterised length. On each cycle in which the input is marked valid, it takes four consecutive element pairs. Four parallel multipliers form the four products, and each product is registered. A two-level pairwise adder tree reduces the four products to one term, and that term is also registered. An accumulator stage then adds the term into a running sum. Because of these pipeline registers, no register-to-register path holds more than one multiplier.

A start pulse clears the running sum and the beat count, and any operands still in the pipeline are dropped. The caller then streams N/4 valid beats. Gaps between the beats are allowed. When the contribution of the final beat reaches the sum, a one-cycle done flag is raised. The result then stays unchanged until the next start. The sum is wide enough that a full vector of extreme operands cannot overflow it.

Top module: `dotp_pipe4`

## Requirements
- R1: During and after a synchronous active-low reset, `result` is 0 and `done` is 0. The first vector after reset needs no start pulse.
- R2: Each valid beat carries four elements. Lane k occupies bits [k*W +: W] of `a_lanes` and of `b_lanes` and is element 4*j+k of beat j. All operands are two's complement. After the last beat, `result` equals the signed sum over all N elements of A[i]*B[i].
- R3: `result` is 2*W + log2(N) bits wide, signed. It holds the exact sum even when every operand is the most negative value, or when every pair is the most positive value times the most negative value.
- R4: The last accepted beat is sampled at clock edge L. `done` is 0 after edges L and L+1, and it is 1 after edge L+2, with the final `result`. For back-to-back beats this gives 3 + N/4 − 1 edges, counted from the first beat's edge.
- R5: `done` is high for exactly one cycle per vector. `result` keeps its final value after `done` falls.
- R6: A cycle with `in_valid` low does not change the sum, whatever data is on the operand ports.
- R7: A `start` pulse sets `result` to 0 and `done` to 0 one edge later. A beat presented in the same cycle as `start` is ignored. Beats still inside the pipeline when `start` arrives are discarded.
- R8: Once N/4 beats have been accepted, further valid beats are ignored until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Clears the sum and the beat count and begins a new vector |
| in_valid | input | 1 | Marks the operand lanes as a beat |
| a_lanes | input | 4*W | Four A elements; lane k in bits [k*W +: W] |
| b_lanes | input | 4*W | Four B elements; lane k in bits [k*W +: W] |
| result | output | 2*W+log2(N) | Signed running and final sum |
| done | output | 1 | One-cycle flag: the last beat has been added |

## Verification
Each beat reaches the sum three edges after it is sampled: one edge for the multipliers, one for the tree and one for the accumulator. The bench drives inputs on falling edges. After the last beat it steps one falling edge at a time, so that `done` is checked low one edge and two edges after the last beat, high with the reference sum three edges after it, and low again with an unchanged `result` on the following edge. The start and overrun cases sample `result` on each falling edge across the whole window in which discarded beats would otherwise have reached the sum.

// File: rtl/dotp_pkg.sv
// Shared constants for the four-lane dot-product accumulator.
// Assumes the lane count and tree shape are fixed by the architecture.
package dotp_pkg;
    localparam int LANES       = 4;  // element pairs per beat
    localparam int TREE_LEVELS = 2;  // pairwise adder levels reducing LANES products
endpackage

// File: rtl/dotp_lane_mul.sv
// Multiply stage: one signed multiplier per lane, each product registered.
// Assumes the operands are two's complement, W bits, packed lane k at [k*W +: W].
// flush drops the valid tag, so an aborted beat never reaches the tree.
module dotp_lane_mul
    import dotp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     v_in,
    input  logic                     last_in,
    input  logic [LANES*W-1:0]       a_in,
    input  logic [LANES*W-1:0]       b_in,
    output logic                     v_out,
    output logic                     last_out,
    output logic [LANES*2*W-1:0]     prod_out
);
    localparam int PW = 2 * W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic signed [W-1:0]  a_k;
        logic signed [W-1:0]  b_k;
        logic signed [PW-1:0] p_q;
        assign a_k = a_in[k*W +: W];
        assign b_k = b_in[k*W +: W];

        // Register the full-width signed product of this lane.
        always_ff @(posedge clk) begin
            if (!rst_n) p_q <= '0;
            else        p_q <= a_k * b_k;
        end
        assign prod_out[k*PW +: PW] = p_q;
    end

    // Carry the beat tag alongside the products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_out    <= 1'b0;
            last_out <= 1'b0;
        end else begin
            v_out    <= v_in && !flush;
            last_out <= last_in;
        end
    end
endmodule

// File: rtl/dotp_tree_add.sv
// Reduction stage: two pairwise adders, then one, all sign-extended; the
// tree output is registered. Assumes exactly four lanes (two levels).
module dotp_tree_add
    import dotp_pkg::*;
#(
    parameter int PW = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   v_in,
    input  logic                   last_in,
    input  logic [LANES*PW-1:0]    prod_in,
    output logic                   v_out,
    output logic                   last_out,
    output logic [PW+TREE_LEVELS-1:0] sum_out
);
    localparam int L1W = PW + 1;
    localparam int L2W = PW + TREE_LEVELS;

    logic signed [L1W-1:0] lvl1 [LANES/2];
    logic signed [L2W-1:0] lvl2;
    logic signed [L2W-1:0] sum_q;

    for (genvar m = 0; m < LANES/2; m++) begin : g_pair
        logic signed [PW-1:0] lo;
        logic signed [PW-1:0] hi;
        assign lo = prod_in[(2*m)*PW +: PW];
        assign hi = prod_in[(2*m+1)*PW +: PW];
        assign lvl1[m] = L1W'(lo) + L1W'(hi);
    end

    assign lvl2 = L2W'(lvl1[0]) + L2W'(lvl1[1]);

    // Register the tree sum and its beat tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q    <= '0;
            v_out    <= 1'b0;
            last_out <= 1'b0;
        end else begin
            sum_q    <= lvl2;
            v_out    <= v_in && !flush;
            last_out <= last_in;
        end
    end
    assign sum_out = sum_q;
endmodule

// File: rtl/dotp_accum.sv
// Accumulate stage: adds each valid tree term into the running sum and
// raises done for one cycle once the final beat's term has been added.
// Assumes AW is wide enough for the full-length sum; clear has priority.
module dotp_accum #(
    parameter int IW = 34,
    parameter int AW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          v_in,
    input  logic          last_in,
    input  logic [IW-1:0] term_in,
    output logic [AW-1:0] acc_out,
    output logic          done_out
);
    logic signed [IW-1:0] term_s;
    logic signed [AW-1:0] acc_q;
    logic                 done_q;

    assign term_s = term_in;

    // Running sum: cleared by start, otherwise summed on valid terms only.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) acc_q <= '0;
        else if (v_in)       acc_q <= acc_q + AW'(term_s);
    end

    // Completion flag: one cycle, in the cycle the final sum appears.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) done_q <= 1'b0;
        else                 done_q <= v_in && last_in;
    end

    assign acc_out  = acc_q;
    assign done_out = done_q;

    // R6: a bubble cycle leaves the sum untouched.
    p_bubble_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !v_in) |=> $stable(acc_q));

    // R7: start empties the sum and drops done.
    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc_q == '0 && !done_q));

    // R5: done never lasts beyond one cycle.
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R5: the final sum holds once done has fallen until a new term or clear.
    p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !clear && !v_in) |=> $stable(acc_q));
endmodule

// File: rtl/dotp_pipe4.sv
// Top: four-lane pipelined dot product. Counts accepted beats, tags the
// last one, and chains multiply -> tree -> accumulate stages.
// Assumes N is a multiple of four; start discards the beat beside it.
module dotp_pipe4
    import dotp_pkg::*;
#(
    parameter int W = 16,
    parameter int N = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          in_valid,
    input  logic [4*W-1:0]                a_lanes,
    input  logic [4*W-1:0]                b_lanes,
    output logic [2*W+$clog2(N)-1:0]      result,
    output logic                          done
);
    localparam int BEATS = N / LANES;
    localparam int CW    = $clog2(BEATS + 1);
    localparam int PW    = 2 * W;
    localparam int TW    = PW + TREE_LEVELS;
    localparam int ACC_W = 2 * W + $clog2(N);

    logic [CW-1:0]         beat_cnt;
    logic                  take;
    logic                  take_last;
    logic                  m_v, m_last, t_v, t_last;
    logic [LANES*PW-1:0]   m_prod;
    logic [TW-1:0]         t_sum;

    assign take      = in_valid && !start && (beat_cnt < CW'(BEATS));
    assign take_last = (beat_cnt == CW'(BEATS - 1));

    // Beat counter: cleared by start, saturates at the vector length.
    always_ff @(posedge clk) begin
        if (!rst_n || start) beat_cnt <= '0;
        else if (take)       beat_cnt <= beat_cnt + CW'(1);
    end

    dotp_lane_mul #(.W(W)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (start),
        .v_in     (take),
        .last_in  (take_last),
        .a_in     (a_lanes),
        .b_in     (b_lanes),
        .v_out    (m_v),
        .last_out (m_last),
        .prod_out (m_prod)
    );

    dotp_tree_add #(.PW(PW)) u_tree (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (start),
        .v_in     (m_v),
        .last_in  (m_last),
        .prod_in  (m_prod),
        .v_out    (t_v),
        .last_out (t_last),
        .sum_out  (t_sum)
    );

    dotp_accum #(.IW(TW), .AW(ACC_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .v_in     (t_v),
        .last_in  (t_last),
        .term_in  (t_sum),
        .acc_out  (result),
        .done_out (done)
    );

    // R8: the count never passes the vector length.
    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        beat_cnt <= CW'(BEATS));

    // R8: a saturated counter lets no beat into the multiply stage.
    p_overrun_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_cnt == CW'(BEATS) && !start) |=> !m_v);

    // R4: done follows the last accepted beat by three edges.
    p_done_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_last) ##1 !start ##1 !start |=> done);
endmodule

// File: tb/sim_dotp_pipe4.sv
`timescale 1ns/1ps
module sim_dotp_pipe4;
    localparam int W     = 16;
    localparam int N     = 256;
    localparam int BEATS = N / 4;
    localparam int AW    = 2 * W + $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            in_valid = 1'b0;
    logic [4*W-1:0]  a_lanes = '0;
    logic [4*W-1:0]  b_lanes = '0;
    logic [AW-1:0]   result;
    logic            done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic signed [W-1:0] va [N];
    logic signed [W-1:0] vb [N];
    longint              expect_sum;

    always #10 clk = ~clk;

    dotp_pipe4 #(.W(W), .N(N)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .in_valid (in_valid),
        .a_lanes  (a_lanes),
        .b_lanes  (b_lanes),
        .result   (result),
        .done     (done)
    );

    function automatic longint got_sum();
        return longint'($signed(result));
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // kind 0 random, 1 all most-negative, 2 max times min, 3 small ramp
    task automatic fill(input int kind);
        expect_sum = 0;
        for (int i = 0; i < N; i++) begin
            case (kind)
                0: begin va[i] = W'($urandom); vb[i] = W'($urandom); end
                1: begin va[i] = 16'sh8000; vb[i] = 16'sh8000; end
                2: begin va[i] = 16'sh7fff; vb[i] = 16'sh8000; end
                default: begin va[i] = W'(i - 100); vb[i] = W'(3 * i + 1); end
            endcase
            expect_sum += longint'(va[i]) * longint'(vb[i]);
        end
    endtask

    task automatic put_beat(input int j);
        for (int k = 0; k < 4; k++) begin
            a_lanes[k*W +: W] = va[4*j+k];
            b_lanes[k*W +: W] = vb[4*j+k];
        end
        in_valid = 1'b1;
    endtask

    task automatic garbage();
        a_lanes  = {$urandom, $urandom};
        b_lanes  = {$urandom, $urandom};
        in_valid = 1'b0;
    endtask

    // Stream the loaded vector, optionally with bubbles, and check timing.
    task automatic run_vector(input bit gaps, input string req);
        for (int j = 0; j < BEATS; j++) begin
            if (gaps && (j % 3 == 2)) begin
                @(negedge clk); garbage();
                @(negedge clk); garbage();
            end
            @(negedge clk); put_beat(j);
        end
        @(negedge clk); garbage();
        check(done == 1'b0, "R4 done low one edge after last beat", longint'(done), 0);
        @(negedge clk);
        check(done == 1'b0, "R4 done low two edges after last beat", longint'(done), 0);
        @(negedge clk);
        check(done == 1'b1, "R4 done high three edges after last beat", longint'(done), 1);
        check(got_sum() == expect_sum, req, got_sum(), expect_sum);
        @(negedge clk);
        check(done == 1'b0, "R5 done lasts one cycle", longint'(done), 0);
        check(got_sum() == expect_sum, "R5 result held after done", got_sum(), expect_sum);
    endtask

    task automatic pulse_start(input bit with_beat);
        @(negedge clk);
        start = 1'b1;
        if (with_beat) begin
            a_lanes = {4{16'sh1234}}; b_lanes = {4{16'sh0777}}; in_valid = 1'b1;
        end
        @(negedge clk);
        start = 1'b0; garbage();
        check(got_sum() == 0, "R7 start clears result", got_sum(), 0);
        check(done == 1'b0, "R7 start clears done", longint'(done), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(got_sum() == 0, "R1 result zero in reset", got_sum(), 0);
        check(done == 1'b0, "R1 done low in reset", longint'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(got_sum() == 0, "R1 result zero after reset", got_sum(), 0);
    endtask

    task automatic t_first_after_reset();
        fill(0);
        run_vector(1'b0, "R1 R2 vector right after reset, no start");
    endtask

    task automatic t_random();
        for (int r = 0; r < 3; r++) begin
            pulse_start(1'b0);
            fill(0);
            run_vector(1'b0, "R2 random vector sum");
        end
    endtask

    task automatic t_ramp_with_start_beat();
        pulse_start(1'b1);
        fill(3);
        run_vector(1'b0, "R7 beat beside start ignored, R2 ramp sum");
    endtask

    task automatic t_extremes();
        pulse_start(1'b0);
        fill(1);
        run_vector(1'b0, "R3 all most-negative operands");
        pulse_start(1'b0);
        fill(2);
        run_vector(1'b0, "R3 max times min operands");
    endtask

    task automatic t_bubbles();
        pulse_start(1'b0);
        fill(0);
        run_vector(1'b1, "R6 bubbles with garbage do not change sum");
    endtask

    task automatic t_abort();
        pulse_start(1'b0);
        fill(0);
        for (int j = 0; j < 5; j++) begin
            @(negedge clk); put_beat(j);
        end
        @(negedge clk); start = 1'b1; garbage();
        @(negedge clk); start = 1'b0;
        for (int c = 0; c < 5; c++) begin
            check(got_sum() == 0, "R7 in-flight beats discarded", got_sum(), 0);
            check(done == 1'b0, "R7 no done after abort", longint'(done), 0);
            @(negedge clk);
        end
        fill(0);
        run_vector(1'b0, "R7 clean vector after abort");
    endtask

    task automatic t_overrun();
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            a_lanes = {4{16'sh4321}}; b_lanes = {4{16'sh1111}}; in_valid = 1'b1;
        end
        @(negedge clk); garbage();
        for (int c = 0; c < 5; c++) begin
            check(got_sum() == expect_sum, "R8 extra beats ignored", got_sum(), expect_sum);
            check(done == 1'b0, "R8 no done from extra beats", longint'(done), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        t_reset();
        t_first_after_reset();
        t_random();
        t_ramp_with_start_beat();
        t_extremes();
        t_overrun();
        t_bubbles();
        t_abort();
        t_overrun();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule